// File: doc/BRIEF.md
# Byte/Word Memory and Input Tape Port

This block performs the memory and input operations of a W-bit register machine: it writes a single byte or a whole word into a byte-addressed memory, reads a byte or a word back, and takes the next word from a sequential input tape. Each operation arrives with a 3-bit code, an absolute address, and a store value. The address is taken either from an immediate field or from a register's contents, chosen by a select bit. There is no base-plus-offset addressing.

The memory is held inside the block as an array of `MEM_BYTES` bytes. It is cleared by reset. The tape sits outside the block and is seen as a stream that shows the word at its head and a valid bit. The block raises a pop strobe in the cycle it takes that word. Every operation gives a registered result word and a flag one cycle after issue. Those two values go to the destination register and the machine's flag.

Top module: `memtape_unit`

## Requirements
- R1: While `rst_n` is low and after it is released, `res_valid`, `res_data`, `res_flag` and `tape_pop` are 0, and every memory byte reads as 0 until it is written.
- R2: `addr_sel` = 1 takes the address from `reg_addr`; `addr_sel` = 0 takes it from `imm_addr`; the other address input has no effect.
- R3: Code 1 (word store) at an in-range aligned address A writes the W/8 bytes A .. A+W/8-1 in little-endian order (byte A gets bits 7:0); result 0, flag 0.
- R4: Code 0 (byte store) writes only bits 7:0 of `store_data` to byte A; every other byte is unchanged; result 0, flag 0.
- R5: Code 2 (byte load) returns byte A zero-extended to W bits, flag 0.
- R6: Code 3 (word load) at an in-range aligned address returns bytes A .. A+W/8-1 assembled little-endian, flag 0.
- R7: A word store or word load whose address is not a multiple of W/8 sets the flag to 1, returns 0 and leaves memory unchanged.
- R8: An operation issued with `op_valid` high at a rising edge presents `res_valid` = 1 with its result after that edge; a load issued in the cycle after a store sees the stored data.
- R9: Code 4 (tape read) with `tape_valid` = 1 returns `tape_data` with flag 0 and raises `tape_pop` in the issue cycle only, so exactly one entry is consumed.
- R10: Code 4 with `tape_valid` = 0 returns 0 with flag 1 and keeps `tape_pop` low.
- R11: Any byte or word access whose address is `MEM_BYTES` or above sets the flag to 1, returns 0 and writes nothing.
- R12: Codes 5, 6 and 7 change no memory byte, do not pop the tape, and return 0 with flag 0.
- R13: With `op_valid` low the memory and tape are untouched, `res_valid` is 0 in the next cycle, and `res_data` and `res_flag` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 3 | Operation code (see R3 to R12) |
| addr_sel | input | 1 | 1 = register address, 0 = immediate address |
| imm_addr | input | W | Immediate address |
| reg_addr | input | W | Register-sourced address |
| store_data | input | W | Value to store |
| tape_valid | input | 1 | Tape has a word at its head |
| tape_data | input | W | Word at the tape head |
| tape_pop | output | 1 | Head word is consumed this cycle |
| res_valid | output | 1 | Result belongs to the operation of the previous cycle |
| res_data | output | W | Load or read result |
| res_flag | output | 1 | Fault or empty-tape flag |

## Verification
The directed stimulus overlays a byte store on a word that has already been stored. Reading the word back shows the lane order and shows that the neighbouring bytes are kept. It also issues back-to-back store and load pairs, which would expose a stale read path. Misaligned and out-of-range addresses are checked by a load of the same location afterwards, so a write that should have been suppressed becomes visible. The tape is drained past its end, which tells an empty-tape read apart from a zero-valued entry. A long random mix of all eight codes, both address sources, idle cycles and occasional refills of the tape is then compared with a byte-array model kept in the bench.

// File: rtl/memtape_pkg.sv
package memtape_pkg;

  localparam logic [2:0] OPC_STORE_B = 3'd0;
  localparam logic [2:0] OPC_STORE_W = 3'd1;
  localparam logic [2:0] OPC_LOAD_B  = 3'd2;
  localparam logic [2:0] OPC_LOAD_W  = 3'd3;
  localparam logic [2:0] OPC_TAPE_RD = 3'd4;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_STORE_B,
    ACT_STORE_W,
    ACT_LOAD_B,
    ACT_LOAD_W,
    ACT_TAPE
  } act_e;

  function automatic act_e decode_op(input logic [2:0] code);
    act_e a;
    case (code)
      OPC_STORE_B: a = ACT_STORE_B;
      OPC_STORE_W: a = ACT_STORE_W;
      OPC_LOAD_B:  a = ACT_LOAD_B;
      OPC_LOAD_W:  a = ACT_LOAD_W;
      OPC_TAPE_RD: a = ACT_TAPE;
      default:     a = ACT_NONE;
    endcase
    return a;
  endfunction

endpackage

// File: rtl/memtape_addr.sv
module memtape_addr #(
  parameter int W         = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic                         addr_sel,
  input  logic [W-1:0]                 imm_addr,
  input  logic [W-1:0]                 reg_addr,
  input  logic                         is_word,
  output logic [$clog2(MEM_BYTES)-1:0] phys_addr,
  output logic                         fault
);
  localparam int NB = W / 8;
  localparam int AW = $clog2(MEM_BYTES);
  localparam logic [W-1:0] LANE_MASK = W'(NB - 1);
  localparam logic [W-1:0] LIMIT     = W'(MEM_BYTES);

  logic [W-1:0] eff_addr;
  logic         beyond;
  logic         unaligned;

  // absolute addressing only: one source or the other, no offset adder
  always_comb begin
    eff_addr  = addr_sel ? reg_addr : imm_addr;
    beyond    = (eff_addr >= LIMIT);
    unaligned = is_word && ((eff_addr & LANE_MASK) != '0);
    fault     = beyond || unaligned;
    phys_addr = eff_addr[AW-1:0];
  end

endmodule

// File: rtl/memtape_bytes.sv
module memtape_bytes #(
  parameter int W         = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_word,
  input  logic [$clog2(MEM_BYTES)-1:0] addr,
  input  logic [W-1:0]                 wr_data,
  output logic [7:0]                   rd_byte,
  output logic [W-1:0]                 rd_word
);
  localparam int NB = W / 8;
  localparam int AW = $clog2(MEM_BYTES);
  localparam logic [AW-1:0] LANE_MASK = AW'(NB - 1);

  logic [7:0]    mem_q [MEM_BYTES];
  logic [7:0]    mem_d [MEM_BYTES];
  logic [AW-1:0] base_addr;

  assign base_addr = addr & ~LANE_MASK;

  // next-state: byte store touches one entry, word store touches NB lanes
  always_comb begin
    mem_d = mem_q;
    if (wr_word) begin
      for (int lane = 0; lane < NB; lane++) begin
        mem_d[base_addr + AW'(lane)] = wr_data[8*lane +: 8];
      end
    end else begin
      mem_d[addr] = wr_data[7:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < MEM_BYTES; i++) begin
        mem_q[i] <= 8'h00;
      end
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  assign rd_byte = mem_q[addr];

  // word read: one lane mux per byte of the word, low address in low lane
  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign rd_word[8*g +: 8] = mem_q[base_addr + AW'(g)];
  end

endmodule

// File: rtl/memtape_tape.sv
module memtape_tape #(
  parameter int W = 32
) (
  input  logic         req,
  input  logic         tape_valid,
  input  logic [W-1:0] tape_data,
  output logic         pop,
  output logic [W-1:0] word,
  output logic         empty
);
  // an exhausted tape never stalls: it answers zero with the flag set
  always_comb begin
    pop   = req && tape_valid;
    empty = req && !tape_valid;
    word  = pop ? tape_data : '0;
  end

endmodule

// File: rtl/memtape_unit.sv
module memtape_unit
  import memtape_pkg::*;
#(
  parameter int W         = 32,
  parameter int MEM_BYTES = 256
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic         addr_sel,
  input  logic [W-1:0] imm_addr,
  input  logic [W-1:0] reg_addr,
  input  logic [W-1:0] store_data,
  input  logic         tape_valid,
  input  logic [W-1:0] tape_data,
  output logic         tape_pop,
  output logic         res_valid,
  output logic [W-1:0] res_data,
  output logic         res_flag
);
  localparam int AW = $clog2(MEM_BYTES);

  act_e          act;
  logic          is_word;
  logic          is_store;
  logic          addr_fault;
  logic [AW-1:0] phys_addr;
  logic          wr_en;
  logic [7:0]    rd_byte;
  logic [W-1:0]  rd_word;
  logic [W-1:0]  tape_word;
  logic          tape_empty;

  logic          valid_d, valid_q;
  logic [W-1:0]  data_d, data_q;
  logic          flag_d, flag_q;

  assign act      = op_valid ? decode_op(op_code) : ACT_NONE;
  assign is_word  = (act == ACT_STORE_W) || (act == ACT_LOAD_W);
  assign is_store = (act == ACT_STORE_B) || (act == ACT_STORE_W);
  assign wr_en    = is_store && !addr_fault;

  memtape_addr #(.W(W), .MEM_BYTES(MEM_BYTES)) u_addr (
    .addr_sel  (addr_sel),
    .imm_addr  (imm_addr),
    .reg_addr  (reg_addr),
    .is_word   (is_word),
    .phys_addr (phys_addr),
    .fault     (addr_fault)
  );

  memtape_bytes #(.W(W), .MEM_BYTES(MEM_BYTES)) u_mem (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_word (act == ACT_STORE_W),
    .addr    (phys_addr),
    .wr_data (store_data),
    .rd_byte (rd_byte),
    .rd_word (rd_word)
  );

  memtape_tape #(.W(W)) u_tape (
    .req        (act == ACT_TAPE),
    .tape_valid (tape_valid),
    .tape_data  (tape_data),
    .pop        (tape_pop),
    .word       (tape_word),
    .empty      (tape_empty)
  );

  // result next-state
  always_comb begin
    valid_d = op_valid;
    data_d  = '0;
    flag_d  = 1'b0;
    case (act)
      ACT_STORE_B, ACT_STORE_W: begin
        flag_d = addr_fault;
      end
      ACT_LOAD_B: begin
        flag_d = addr_fault;
        data_d = addr_fault ? '0 : W'(rd_byte);
      end
      ACT_LOAD_W: begin
        flag_d = addr_fault;
        data_d = addr_fault ? '0 : rd_word;
      end
      ACT_TAPE: begin
        flag_d = tape_empty;
        data_d = tape_word;
      end
      default: begin
        data_d = '0;
        flag_d = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      flag_q <= 1'b0;
    end else if (op_valid) begin
      data_q <= data_d;
      flag_q <= flag_d;
    end
  end

  assign res_valid = valid_q;
  assign res_data  = data_q;
  assign res_flag  = flag_q;

endmodule

// File: rtl/memtape_unit_chk.sv
module memtape_unit_chk
  import memtape_pkg::*;
#(
  parameter int W         = 32,
  parameter int MEM_BYTES = 256
) (
  input logic         clk,
  input logic         rst_n,
  input logic         op_valid,
  input logic [2:0]   op_code,
  input logic         addr_sel,
  input logic [W-1:0] imm_addr,
  input logic [W-1:0] reg_addr,
  input logic         tape_valid,
  input logic [W-1:0] tape_data,
  input logic         tape_pop,
  input logic         res_valid,
  input logic [W-1:0] res_data,
  input logic         res_flag
);
  localparam int NB = W / 8;

  logic [W-1:0] chk_addr;
  logic         word_op;
  logic         bad_align;
  assign chk_addr  = addr_sel ? reg_addr : imm_addr;
  assign word_op   = (op_code == OPC_STORE_W) || (op_code == OPC_LOAD_W);
  assign bad_align = (chk_addr % W'(NB)) != '0;

  // R8
  issue_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> res_valid);

  // R13
  idle_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_valid && $stable(res_data) && $stable(res_flag));

  // R13
  idle_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !tape_pop);

  // R9
  tape_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tape_pop |=> res_valid && !res_flag && res_data == $past(tape_data));

  // R10
  tape_dry_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_TAPE_RD && !tape_valid) |-> !tape_pop);

  // R10
  tape_dry_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_TAPE_RD && !tape_valid) |=> res_flag && res_data == '0);

  // R7
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && word_op && bad_align) |=> res_flag && res_data == '0);

  // R5
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_code == OPC_LOAD_B) |=> res_data[W-1:8] == '0);

endmodule

bind memtape_unit memtape_unit_chk #(.W(W), .MEM_BYTES(MEM_BYTES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .op_valid   (op_valid),
  .op_code    (op_code),
  .addr_sel   (addr_sel),
  .imm_addr   (imm_addr),
  .reg_addr   (reg_addr),
  .tape_valid (tape_valid),
  .tape_data  (tape_data),
  .tape_pop   (tape_pop),
  .res_valid  (res_valid),
  .res_data   (res_data),
  .res_flag   (res_flag)
);

// File: tb/memtape_unit_test.sv
module memtape_unit_test;
  localparam int W  = 32;
  localparam int MB = 256;
  localparam int NB = W / 8;
  localparam int TAPE_MAX = 16;

  logic         clk;
  logic         rst_n;
  logic         op_valid;
  logic [2:0]   op_code;
  logic         addr_sel;
  logic [W-1:0] imm_addr;
  logic [W-1:0] reg_addr;
  logic [W-1:0] store_data;
  logic         tape_valid;
  logic [W-1:0] tape_data;
  logic         tape_pop;
  logic         res_valid;
  logic [W-1:0] res_data;
  logic         res_flag;

  memtape_unit #(.W(W), .MEM_BYTES(MB)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .addr_sel(addr_sel), .imm_addr(imm_addr), .reg_addr(reg_addr),
    .store_data(store_data), .tape_valid(tape_valid), .tape_data(tape_data),
    .tape_pop(tape_pop), .res_valid(res_valid), .res_data(res_data),
    .res_flag(res_flag)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  logic [7:0]   ref_mem [MB];
  logic [W-1:0] tape_q  [TAPE_MAX];
  int tape_len;
  int tape_idx;
  int checks;
  int fails;
  bit finished;

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill_tape(input int n);
    for (int i = 0; i < n; i++) tape_q[i] = $urandom;
    tape_len = n;
    tape_idx = 0;
  endtask

  // called at a falling edge; returns at the next falling edge with results checked
  task automatic do_op(input logic [2:0] op, input logic sel, input logic [W-1:0] a,
                       input logic [W-1:0] d, input string req);
    logic [W-1:0] ed;
    logic         ef;
    logic         ep;
    logic         oor;
    logic         mis;
    int           ix;
    op_valid   = 1'b1;
    op_code    = op;
    addr_sel   = sel;
    imm_addr   = sel ? $urandom : a;
    reg_addr   = sel ? a : $urandom;
    store_data = d;
    tape_valid = (tape_idx < tape_len);
    tape_data  = tape_valid ? tape_q[tape_idx] : $urandom;
    oor = (a >= W'(MB));
    mis = (a % W'(NB)) != '0;
    ix  = oor ? 0 : int'(a);
    ed = '0; ef = 1'b0; ep = 1'b0;
    case (op)
      3'd0: begin ef = oor; if (!oor) ref_mem[ix] = d[7:0]; end
      3'd1: begin
        ef = oor || mis;
        if (!ef) for (int i = 0; i < NB; i++) ref_mem[ix + i] = d[8*i +: 8];
      end
      3'd2: begin ef = oor; ed = oor ? '0 : W'(ref_mem[ix]); end
      3'd3: begin
        ef = oor || mis;
        if (!ef) for (int i = 0; i < NB; i++) ed[8*i +: 8] = ref_mem[ix + i];
      end
      3'd4: begin
        ep = (tape_idx < tape_len);
        ef = !ep;
        ed = ep ? tape_q[tape_idx] : '0;
      end
      default: begin ed = '0; ef = 1'b0; end
    endcase
    #1;
    check({req, " pop"}, W'(tape_pop), W'(ep));
    @(negedge clk);
    if (ep) tape_idx++;
    check({req, " valid"}, W'(res_valid), W'(1));
    check({req, " data"}, res_data, ed);
    check({req, " flag"}, W'(res_flag), W'(ef));
  endtask

  task automatic idle_cycle(input string req);
    logic [W-1:0] hold_d;
    logic         hold_f;
    hold_d     = res_data;
    hold_f     = res_flag;
    op_valid   = 1'b0;
    op_code    = 3'($urandom);
    addr_sel   = 1'($urandom);
    imm_addr   = $urandom % MB;
    reg_addr   = $urandom % MB;
    store_data = $urandom;
    tape_valid = (tape_idx < tape_len);
    tape_data  = tape_valid ? tape_q[tape_idx] : $urandom;
    #1;
    check({req, " idle pop"}, W'(tape_pop), '0);
    @(negedge clk);
    check({req, " idle valid"}, W'(res_valid), '0);
    check({req, " idle data hold"}, res_data, hold_d);
    check({req, " idle flag hold"}, W'(res_flag), W'(hold_f));
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [2:0]   op;
    logic [W-1:0] a;
    checks = 0; fails = 0; finished = 1'b0;
    void'($urandom(32'h1234_5eed));
    for (int i = 0; i < MB; i++) ref_mem[i] = 8'h00;
    tape_len = 0; tape_idx = 0;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; addr_sel = 1'b0;
    imm_addr = '0; reg_addr = '0; store_data = '0;
    tape_valid = 1'b0; tape_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset valid", W'(res_valid), '0);
    check("R1 reset data", res_data, '0);
    check("R1 reset flag", W'(res_flag), '0);
    check("R1 reset pop", W'(tape_pop), '0);
    rst_n = 1'b1;
    @(negedge clk);
    do_op(3'd3, 1'b0, 32'd0,   '0, "R1 cleared word 0");
    do_op(3'd2, 1'b1, 32'd200, '0, "R1 cleared byte 200");
    // R3 R6 R8 word store then back-to-back reads
    do_op(3'd1, 1'b0, 32'd8, 32'h1122_3344, "R3 word store");
    do_op(3'd2, 1'b0, 32'd8,  '0, "R3 R8 lane0 byte");
    do_op(3'd2, 1'b1, 32'd11, '0, "R3 R5 lane3 byte");
    do_op(3'd3, 1'b1, 32'd8,  '0, "R6 word load");
    // R4 R2 byte store keeps only low byte
    do_op(3'd0, 1'b1, 32'd9, 32'hAABB_CCDD, "R4 R2 byte store");
    do_op(3'd3, 1'b0, 32'd8, '0, "R4 merged word");
    // R5 zero extension of a high byte
    do_op(3'd0, 1'b0, 32'd20, 32'h0000_00F0, "R5 store");
    do_op(3'd2, 1'b0, 32'd20, '0, "R5 zero-extend");
    // R7 misalignment
    do_op(3'd1, 1'b0, 32'd13, 32'hDEAD_BEEF, "R7 misaligned store");
    do_op(3'd3, 1'b0, 32'd12, '0, "R7 memory untouched");
    do_op(3'd3, 1'b1, 32'd10, '0, "R7 misaligned load");
    // R11 out of range
    do_op(3'd0, 1'b0, W'(MB + 5), 32'h77, "R11 byte store beyond");
    do_op(3'd2, 1'b0, 32'd5, '0, "R11 no wrap write");
    do_op(3'd3, 1'b1, 32'hFFFF_FFF0, '0, "R11 word load beyond");
    do_op(3'd1, 1'b0, W'(MB - NB), 32'hCAFE_F00D, "R11 top word store");
    do_op(3'd3, 1'b0, W'(MB - NB), '0, "R11 top word load");
    // R9 R10 tape
    fill_tape(3);
    do_op(3'd4, 1'b0, '0, '0, "R9 tape 0");
    do_op(3'd4, 1'b0, '0, '0, "R9 tape 1");
    idle_cycle("R13 between reads");
    do_op(3'd4, 1'b1, '0, '0, "R9 tape 2");
    do_op(3'd4, 1'b0, '0, '0, "R10 tape dry");
    do_op(3'd4, 1'b0, '0, '0, "R10 tape dry again");
    // R12 unused codes
    fill_tape(1);
    do_op(3'd6, 1'b0, 32'd8, 32'h5555_5555, "R12 code 6");
    do_op(3'd5, 1'b0, 32'd8, 32'h5555_5555, "R12 code 5");
    do_op(3'd7, 1'b1, 32'd8, 32'h5555_5555, "R12 code 7");
    do_op(3'd3, 1'b0, 32'd8, '0, "R12 memory unchanged");
    do_op(3'd4, 1'b0, '0, '0, "R12 tape kept");
    // R13 idle run
    idle_cycle("R13 idle a");
    idle_cycle("R13 idle b");
    do_op(3'd3, 1'b0, 32'd8, '0, "R13 memory after idle");
    // random mix
    fill_tape(TAPE_MAX);
    for (int n = 0; n < 1500; n++) begin
      if (($urandom % 8) == 0) begin
        idle_cycle("R13 random");
      end else begin
        op = 3'($urandom);
        a  = W'($urandom % (MB + MB / 8));
        if ((op == 3'd1 || op == 3'd3) && ($urandom % 4) != 0) a = a & ~W'(NB - 1);
        if (($urandom % 64) == 0) a = $urandom | 32'h8000_0000;
        if (tape_idx == tape_len && ($urandom % 8) == 0) fill_tape(1 + ($urandom % TAPE_MAX));
        case (op)
          3'd0: do_op(op, 1'($urandom), a, $urandom, "R4 R11 random byte store");
          3'd1: do_op(op, 1'($urandom), a, $urandom, "R3 R7 random word store");
          3'd2: do_op(op, 1'($urandom), a, '0, "R5 R2 random byte load");
          3'd3: do_op(op, 1'($urandom), a, '0, "R6 R8 random word load");
          3'd4: do_op(op, 1'($urandom), a, '0, "R9 R10 random tape read");
          default: do_op(op, 1'($urandom), a, $urandom, "R12 random unused code");
        endcase
      end
    end
    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule